// File: doc/BRIEF.md
# Serial Shadow Register Load Port

This block is the receiving end of a three-wire configuration link: a serial data input, a serial clock and an active-low enable. While the enable is held low, every rising edge of the serial clock pushes one data bit into a chain of shadow stages. The bit that drops off the far end of the chain appears on a serial output, so that several devices can share the clock and enable with their data lines daisy-chained. The active configuration word is not disturbed by shifting.

The first clock edge that sees the enable high again ends the load window. On that edge the whole shadow chain is copied in parallel into the active configuration register, which feeds the rest of the chip, and a one-cycle update strobe is raised. If more bits were sent than there are stages, the oldest ones have already left through the serial output, so only the most recent frame stays in the chain. A synchronous active-high reset clears every register in the block.

Top module: `sreg_cfg_port`

## Requirements
- R1: A clock edge with `rst` high clears the shadow chain, the active word and the strobe, so that afterwards `cfg_q` is 0, `sdo` is 0 and `cfg_upd` is 0; this holds even if that edge would otherwise have ended a load window.
- R2: A clock edge sampled with `sen_n` high does not shift: the shadow chain, and therefore `sdo`, keeps its value whatever `sdi` is.
- R3: `cfg_q` changes only on the edge that ends a load window; edges that shift leave it unchanged.
- R4: A load window ends on the first edge that samples `sen_n` high after an edge that sampled it low; on that edge `cfg_q` takes the shadow chain as it stood before the edge, with stage k on `cfg_q[k-1]`, so the first bit of a 21-bit frame lands on `cfg_q[20]` and the last on `cfg_q[0]`.
- R5: When more than 21 bits are shifted in one window, the loaded word holds only the last 21 bits sent, in the order of R4.
- R6: During a load window a bit sent on one edge appears on `sdo` right after the twentieth following shifting edge, i.e. `sdo` is `sdi` delayed by 20 shifting edges, and it changes on the shifting edge itself.
- R7: The first 20 values on `sdo` in a new window are the previous shadow contents, stage 20 first down to stage 1.
- R8: `cfg_upd` is high for exactly one cycle, right after the edge that ends a load window, and low at all other times.
- R9: An enable high for a single edge between two windows ends the first window and loads it; the next edge with `sen_n` low shifts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data in |
| sen_n | input | 1 | Load window enable, active low |
| sdo | output | 1 | Serial data out, value of the last shadow stage |
| cfg_q | output | NSTAGE (21) | Active configuration word |
| cfg_upd | output | 1 | One-cycle strobe after the active word is loaded |

## Verification
The edge that ends a load window both copies the chain and has to leave it unshifted, and the same edge can coincide with a reset or be followed at once by the first shift of a new window. The bench provokes these by closing windows with a single high edge before reopening, and by raising reset exactly on a closing edge. It judges them against a bench model: the loaded word must be the pre-edge chain, reset must win with no strobe, and the new window's `sdo` stream must replay the old chain before any new bit arrives.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int unsigned DEF_STAGES = 21;

    // Decoded action for one serial clock edge.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'b00,
        ACT_SHIFT = 2'b01,
        ACT_LOAD  = 2'b10
    } edge_act_e;

    typedef struct packed {
        edge_act_e act;
        logic      win_q;   // enable seen low on the previous edge
    } ctl_t;

    // Decide what the current edge does from the sampled enable and
    // the window flag recorded on the previous edge.
    function automatic edge_act_e decode_edge(input logic en_n, input logic win_q);
        if (!en_n)
            return ACT_SHIFT;
        else if (win_q)
            return ACT_LOAD;
        else
            return ACT_IDLE;
    endfunction

endpackage

// File: rtl/sreg_ctl.sv
module sreg_ctl
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    output ctl_t ctl
);

    logic win_q;

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= 1'b0;
        else
            win_q <= ~en_n;
    end

    always_comb begin
        ctl.win_q = win_q;
        ctl.act   = decode_edge(en_n, win_q);
    end

endmodule

// File: rtl/sreg_chain.sv
module sreg_chain
    import sreg_pkg::*;
#(
    parameter int unsigned NSTAGE = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              din,
    output logic [NSTAGE-1:0] stages,
    output logic              dout
);

    localparam int unsigned LAST = NSTAGE - 1;

    logic [NSTAGE-1:0] sh_q;

    // Stage 1 is bit 0; each stage takes the one below it on a shift.
    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        logic nxt;
        if (g == 0) begin : g_head
            assign nxt = din;
        end else begin : g_body
            assign nxt = sh_q[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst)
                sh_q[g] <= 1'b0;
            else if (ctl.act == ACT_SHIFT)
                sh_q[g] <= nxt;
        end
    end

    assign stages = sh_q;
    assign dout   = sh_q[LAST];

endmodule

// File: rtl/sreg_active.sv
module sreg_active
    import sreg_pkg::*;
#(
    parameter int unsigned NSTAGE = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [NSTAGE-1:0] shadow,
    output logic [NSTAGE-1:0] word,
    output logic              upd
);

    logic [NSTAGE-1:0] word_q;
    logic              upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= (ctl.act == ACT_LOAD);
            if (ctl.act == ACT_LOAD)
                word_q <= shadow;
        end
    end

    assign word = word_q;
    assign upd  = upd_q;

endmodule

// File: rtl/sreg_cfg_port.sv
module sreg_cfg_port
    import sreg_pkg::*;
#(
    parameter int unsigned NSTAGE = DEF_STAGES
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              sen_n,
    output logic              sdo,
    output logic [NSTAGE-1:0] cfg_q,
    output logic              cfg_upd
);

    ctl_t              ctl;
    logic [NSTAGE-1:0] shadow;

    sreg_ctl u_ctl (
        .clk (sclk),
        .rst (rst),
        .en_n(sen_n),
        .ctl (ctl)
    );

    sreg_chain #(.NSTAGE(NSTAGE)) u_chain (
        .clk   (sclk),
        .rst   (rst),
        .ctl   (ctl),
        .din   (sdi),
        .stages(shadow),
        .dout  (sdo)
    );

    sreg_active #(.NSTAGE(NSTAGE)) u_active (
        .clk   (sclk),
        .rst   (rst),
        .ctl   (ctl),
        .shadow(shadow),
        .word  (cfg_q),
        .upd   (cfg_upd)
    );

endmodule

// File: rtl/sreg_cfg_port_chk.sv
module sreg_cfg_port_chk #(
    parameter int unsigned NSTAGE = 21
) (
    input logic              sclk,
    input logic              rst,
    input logic              sdi,
    input logic              sen_n,
    input logic              sdo,
    input logic [NSTAGE-1:0] cfg_q,
    input logic              cfg_upd,
    input logic [NSTAGE-1:0] shadow
);

    a_r1_reset_clear: assert property (@(posedge sclk)
        rst |=> (cfg_q == '0) && (sdo == 1'b0) && !cfg_upd);

    a_r2_hold_when_high: assert property (@(posedge sclk) disable iff (rst)
        sen_n |=> $stable(shadow));

    a_r3_cfg_only_on_load: assert property (@(posedge sclk) disable iff (rst)
        (!$past(rst) && !$stable(cfg_q)) |-> cfg_upd);

    a_r4_upd_after_close: assert property (@(posedge sclk) disable iff (rst)
        cfg_upd |-> ($past(sen_n) && !$past(sen_n, 2)));

    a_r6_shift_step: assert property (@(posedge sclk) disable iff (rst)
        !sen_n |=> (shadow[0] == $past(sdi)) && (sdo == $past(shadow[NSTAGE-2])));

    a_r8_single_pulse: assert property (@(posedge sclk) disable iff (rst)
        cfg_upd |=> !cfg_upd);

endmodule

bind sreg_cfg_port sreg_cfg_port_chk #(.NSTAGE(NSTAGE)) u_chk (
    .sclk   (sclk),
    .rst    (rst),
    .sdi    (sdi),
    .sen_n  (sen_n),
    .sdo    (sdo),
    .cfg_q  (cfg_q),
    .cfg_upd(cfg_upd),
    .shadow (shadow)
);

// File: tb/sreg_cfg_port_test.sv
module sreg_cfg_port_test;

    localparam int N = 21;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sdi = 1'b0;
    logic         sen_n = 1'b1;
    logic         sdo;
    logic [N-1:0] cfg_q;
    logic         cfg_upd;

    int n_chk  = 0;
    int n_fail = 0;

    // Bench model state
    logic [N-1:0] m_sh  = '0;
    logic [N-1:0] m_act = '0;
    logic         m_win = 1'b0;
    logic         m_upd = 1'b0;

    always #10 clk = ~clk;

    sreg_cfg_port #(.NSTAGE(N)) uut (
        .sclk   (clk),
        .rst    (rst),
        .sdi    (sdi),
        .sen_n  (sen_n),
        .sdo    (sdo),
        .cfg_q  (cfg_q),
        .cfg_upd(cfg_upd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One edge: drive at negedge, advance model at posedge, compare after it.
    task automatic step(input logic r, input logic d, input logic en, input string tag);
        @(negedge clk);
        rst = r; sdi = d; sen_n = en;
        @(posedge clk);
        if (r) begin
            m_sh = '0; m_act = '0; m_win = 1'b0; m_upd = 1'b0;
        end else begin
            m_upd = en && m_win;
            if (en && m_win) m_act = m_sh;
            if (!en) m_sh = {m_sh[N-2:0], d};
            m_win = !en;
        end
        #2;
        check({tag, " sdo"}, {31'd0, sdo}, {31'd0, m_sh[N-1]});
        check({tag, " cfg_q"}, {11'd0, cfg_q}, {11'd0, m_act});
        check({tag, " cfg_upd"}, {31'd0, cfg_upd}, {31'd0, m_upd});
    endtask

    // Expected word from the last 21 bits of a sent list (first sent = index 0).
    function automatic logic [N-1:0] frame_word(input logic [63:0] bits, input int len);
        logic [N-1:0] w = '0;
        for (int i = 0; i < len; i++) w = {w[N-2:0], bits[i]};
        return w;
    endfunction

    task automatic send(input logic [63:0] bits, input int len, input string tag);
        for (int i = 0; i < len; i++) step(1'b0, bits[i], 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] pat;
        logic [N-1:0] prev;
        void'($urandom(32'd4711));

        // R1: reset state
        step(1'b1, 1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b1, "R2 idle");

        // R4: exact 21-bit frame, first bit lands on cfg_q[20]
        pat = 64'h0000_0000_0015_A3C7;
        send(pat, N, "R6 frame");
        step(1'b0, 1'b0, 1'b1, "R4 close");
        check("R4 word map", {11'd0, cfg_q}, {11'd0, frame_word(pat, N)});
        check("R4 first bit on top", {31'd0, cfg_q[N-1]}, {31'd0, pat[0]});
        check("R8 strobe", {31'd0, cfg_upd}, 32'd1);
        step(1'b0, 1'b1, 1'b1, "R8 strobe drop");
        check("R8 one cycle", {31'd0, cfg_upd}, 32'd0);

        // R2: high edges with toggling data leave the chain alone
        for (int i = 0; i < 8; i++) step(1'b0, i[0], 1'b1, "R2 ignored");
        prev = frame_word(pat, N);

        // R7: new window replays the previous chain, stage 20 first; R5: 30 bits
        pat = 64'h0000_0000_2B4D_91E6;
        for (int i = 0; i < 30; i++) begin
            step(1'b0, pat[i], 1'b0, "R3 shifting");
            if (i < 20) check("R7 old stage out", {31'd0, sdo}, {31'd0, prev[N-2-i]});
            else check("R6 delay 20", {31'd0, sdo}, {31'd0, pat[i-20]});
        end
        step(1'b0, 1'b0, 1'b1, "R5 close");
        check("R5 last 21 kept", {11'd0, cfg_q}, {11'd0, frame_word(pat >> 9, N)});

        // R9: single high edge between two windows
        pat = 64'h0000_0000_000F_0F0F;
        send(pat, 5, "R9 win a");
        prev = m_sh;
        step(1'b0, 1'b1, 1'b1, "R9 gap");
        check("R9 loaded a", {11'd0, cfg_q}, {11'd0, prev});
        step(1'b0, 1'b1, 1'b0, "R9 win b");
        check("R9 shifted", {31'd0, cfg_upd}, 32'd0);
        send(pat, 4, "R9 win b");

        // R1: reset on the closing edge wins
        step(1'b1, 1'b0, 1'b1, "R1 reset on close");
        check("R1 no strobe", {31'd0, cfg_upd}, 32'd0);
        check("R1 word clear", {11'd0, cfg_q}, 32'd0);
        step(1'b0, 1'b0, 1'b1, "R8 after reset");

        // Random windows and gaps
        for (int w = 0; w < 60; w++) begin
            int len = 1 + int'($urandom_range(34));
            int gap = 1 + int'($urandom_range(3));
            for (int i = 0; i < len; i++) step(1'b0, 1'($urandom), 1'b0, "R6 random");
            for (int i = 0; i < gap; i++) step(1'b0, 1'($urandom), 1'b1, "R4 random");
        end

        finish_run();
    end

endmodule